// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Window

This block gives a host access to a device-internal memory of 32-bit words, and to a small bank of peripheral registers, through eight directly selected host registers. For the memory, the host first loads a byte address into a pointer register and then moves words through a data register. The block keeps one pointer for reads and another for writes. Every access to a data register advances its pointer by one word (4 bytes). The pointer wraps at the memory size.

Reads are served from a one-word prefetch buffer. Loading the read pointer, or reading a word, starts a fetch of the word at the new read pointer. While that fetch runs, the host port is busy for exactly two cycles. The peripheral side has its own write-setup and read-setup registers. Each setup register holds a 16-bit byte offset and a 2-bit size field. The size field equals the byte count minus one, and it sets which byte lanes are written or returned.

The controller is a three-state machine:
- **IDLE** accepts host requests.
- **FETCH** issues the memory read.
- **LOAD** captures the returned word into the prefetch buffer.

The transitions are:
- **IDLE→FETCH** happens on an accepted read-pointer write or an accepted memory read-data read.
- **FETCH→LOAD** always happens.
- **LOAD→IDLE** always happens.

Reset enters FETCH, so the word at address 0 is prefetched.

Top module: `imw_window`

## Requirements
- R1: During reset `host_ready` is 0. After reset release it stays 0 for exactly two rising edges and is then 1. Both memory pointers read back as 0.
- R2: A write to select 2 (memory write data) stores the word at memory index `wr_ptr[AW+1:2]` and adds 4 to the write pointer.
- R3: A read of select 3 (memory read data) returns the word at the current read pointer and then adds 4 to the read pointer. Every accepted read raises `host_rvalid` for one cycle, on the cycle after acceptance, with the data in `host_rdata`.
- R4: An accepted write to select 0 (read pointer), or an accepted read of select 3, drops `host_ready` for exactly two cycles while the next word is prefetched.
- R5: Pointers are kept modulo MEM_DEPTH*4 bytes, so they wrap. Reads of select 0 and select 1 return the pointer zero-extended.
- R6: A memory write whose word index equals the read pointer's index also updates the prefetched word, so the next read returns the new data.
- R7: A write to select 6 (peripheral write data) goes to register index `offset[15:2]` of the write-setup register. It writes byte lanes 0 through `size` only, where `size` is bits 25:24 of the setup word (3 = full word). Bits 15:0 of the setup word are the offset.
- R8: A read of select 7 (peripheral read data) returns the register at the read-setup offset, with lanes above `size` forced to 0. Indices at or above PER_REGS read 0, and writes to them change nothing.
- R9: A request made while `host_ready` is 0 is ignored: no pointer or register changes and no `host_rvalid`.
- R10: The select encoding is as follows:
  - 0: memory read pointer
  - 1: memory write pointer
  - 2: memory write data
  - 3: memory read data
  - 4: peripheral write setup
  - 5: peripheral read setup
  - 6: peripheral write data
  - 7: peripheral read data

  A read of select 4 or 5 returns `{6'b0, size, 8'b0, offset}`. A read of select 2 or 6 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request strobe, accepted when `host_ready` is 1 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 3 | Register select (see R10) |
| host_wdata | input | 32 | Write data |
| host_ready | output | 1 | Block can accept a request this cycle |
| host_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| host_rdata | output | 32 | Read data |

## Verification
The bench builds the block with MEM_DEPTH=16 and PER_REGS=4. With a 16-word memory, a run of 17 reads or writes wraps a pointer, and random pointer values hit the wrap boundary often. With four peripheral registers, random offsets up to 31 fall half into the unmapped range, so both ignored writes and zero reads occur often.

// File: rtl/imw_pkg.sv
package imw_pkg;

    localparam int OFF_W  = 16;
    localparam int PIDX_W = OFF_W - 2;

    typedef enum logic [2:0] {
        SEL_MRADDR = 3'd0,
        SEL_MWADDR = 3'd1,
        SEL_MWDATA = 3'd2,
        SEL_MRDATA = 3'd3,
        SEL_PWADDR = 3'd4,
        SEL_PRADDR = 3'd5,
        SEL_PWDATA = 3'd6,
        SEL_PRDATA = 3'd7
    } imw_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2
    } imw_state_e;

    // byte enables for lanes 0..size
    function automatic logic [3:0] size_be(input logic [1:0] size);
        logic [3:0] be;
        for (int i = 0; i < 4; i++) be[i] = (i <= int'(size));
        return be;
    endfunction

    function automatic logic [31:0] be_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/imw_sram.sv
module imw_sram #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) store[addr] <= wdata;
            else    rdata       <= store[addr];
        end
    end
endmodule

// File: rtl/imw_periph_regs.sv
module imw_periph_regs
    import imw_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PIDX_W-1:0] widx,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    input  logic [PIDX_W-1:0] ridx,
    output logic [31:0]       rdata
);
    logic [NREGS-1:0][31:0] bank;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [31:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && widx == PIDX_W'(g)) begin
                for (int b = 0; b < 4; b++)
                    if (be[b]) q[8*b +: 8] <= wdata[8*b +: 8];
            end
        end
        assign bank[g] = q;
    end

    // unmapped indices fall through to zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREGS; i++)
            if (ridx == PIDX_W'(i)) rdata = bank[i];
    end
endmodule

// File: rtl/imw_ctrl.sv
module imw_ctrl
    import imw_pkg::*;
#(
    parameter int MEM_DEPTH = 256,
    localparam int AW = $clog2(MEM_DEPTH),
    localparam int PW = AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [2:0]        host_sel,
    input  logic [31:0]       host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [31:0]       host_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              per_we,
    output logic [3:0]        per_be,
    output logic [PIDX_W-1:0] per_widx,
    output logic [31:0]       per_wdata,
    output logic [PIDX_W-1:0] per_ridx,
    input  logic [31:0]       per_rdata,
    output logic [PW-1:0]     rd_ptr_o,
    output logic [PW-1:0]     wr_ptr_o
);
    localparam logic [PW-1:0] STEP = PW'(4);

    imw_state_e state, state_nx;
    imw_sel_e   sel;

    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [31:0]      pbuf;
    logic [OFF_W-1:0] pw_off, pr_off;
    logic [1:0]       pw_size, pr_size;
    logic             accept, acc_wr, acc_rd;
    logic             start_fetch, snoop_hit;
    logic [31:0]      rd_mux;

    assign sel    = imw_sel_e'(host_sel);
    assign accept = host_req && (state == ST_IDLE);
    assign acc_wr = accept && host_we;
    assign acc_rd = accept && !host_we;

    assign start_fetch = (acc_wr && sel == SEL_MRADDR) ||
                         (acc_rd && sel == SEL_MRDATA);
    assign snoop_hit   = (wr_ptr[PW-1:2] == rd_ptr[PW-1:2]);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_fetch) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register: reset enters the fetch path so address 0 is prefetched
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nx;
    end

    // outputs toward memory, peripherals and host
    always_comb begin
        host_ready = (state == ST_IDLE);
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = wr_ptr[PW-1:2];
        per_we     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                mem_we = acc_wr && sel == SEL_MWDATA;
                mem_en = mem_we;
                per_we = acc_wr && sel == SEL_PWDATA;
            end
            ST_FETCH: begin
                mem_en   = 1'b1;
                mem_addr = rd_ptr[PW-1:2];
            end
            ST_LOAD: ;
            default: ;
        endcase
    end

    assign mem_wdata = host_wdata;
    assign per_wdata = host_wdata;
    assign per_be    = size_be(pw_size);
    assign per_widx  = pw_off[OFF_W-1:2];
    assign per_ridx  = pr_off[OFF_W-1:2];

    // read-back multiplexer
    always_comb begin
        unique case (sel)
            SEL_MRADDR: rd_mux = 32'(rd_ptr);
            SEL_MWADDR: rd_mux = 32'(wr_ptr);
            SEL_MRDATA: rd_mux = pbuf;
            SEL_PWADDR: rd_mux = {6'b0, pw_size, 8'b0, pw_off};
            SEL_PRADDR: rd_mux = {6'b0, pr_size, 8'b0, pr_off};
            SEL_PRDATA: rd_mux = per_rdata & be_mask(size_be(pr_size));
            default:    rd_mux = '0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr      <= '0;
            wr_ptr      <= '0;
            pbuf        <= '0;
            pw_off      <= '0;
            pr_off      <= '0;
            pw_size     <= '0;
            pr_size     <= '0;
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            host_rvalid <= acc_rd;
            if (acc_rd) host_rdata <= rd_mux;
            if (acc_rd && sel == SEL_MRDATA) rd_ptr <= rd_ptr + STEP;
            if (acc_wr) begin
                unique case (sel)
                    SEL_MRADDR: rd_ptr <= host_wdata[PW-1:0];
                    SEL_MWADDR: wr_ptr <= host_wdata[PW-1:0];
                    SEL_MWDATA: begin
                        wr_ptr <= wr_ptr + STEP;
                        if (snoop_hit) pbuf <= host_wdata;
                    end
                    SEL_PWADDR: begin
                        pw_off  <= host_wdata[OFF_W-1:0];
                        pw_size <= host_wdata[25:24];
                    end
                    SEL_PRADDR: begin
                        pr_off  <= host_wdata[OFF_W-1:0];
                        pr_size <= host_wdata[25:24];
                    end
                    default: ;
                endcase
            end
            if (state == ST_LOAD) pbuf <= mem_rdata;
        end
    end

    assign rd_ptr_o = rd_ptr;
    assign wr_ptr_o = wr_ptr;
endmodule

// File: rtl/imw_window.sv
module imw_window
    import imw_pkg::*;
#(
    parameter int MEM_DEPTH = 256,
    parameter int PER_REGS  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_we,
    input  logic [2:0]  host_sel,
    input  logic [31:0] host_wdata,
    output logic        host_ready,
    output logic        host_rvalid,
    output logic [31:0] host_rdata
);
    localparam int AW    = $clog2(MEM_DEPTH);
    localparam int PTR_W = AW + 2;

    logic              mem_en, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [31:0]       mem_wdata, mem_rdata;
    logic              per_we;
    logic [3:0]        per_be;
    logic [PIDX_W-1:0] per_widx, per_ridx;
    logic [31:0]       per_wdata, per_rdata;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;

    imw_ctrl #(.MEM_DEPTH(MEM_DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_we(per_we), .per_be(per_be), .per_widx(per_widx),
        .per_wdata(per_wdata), .per_ridx(per_ridx), .per_rdata(per_rdata),
        .rd_ptr_o(rd_ptr), .wr_ptr_o(wr_ptr)
    );

    imw_sram #(.DEPTH(MEM_DEPTH)) u_sram (
        .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    imw_periph_regs #(.NREGS(PER_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(per_we), .widx(per_widx),
        .be(per_be), .wdata(per_wdata), .ridx(per_ridx), .rdata(per_rdata)
    );
endmodule

// File: rtl/imw_window_chk.sv
module imw_window_chk #(
    parameter int PW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_req,
    input logic          host_we,
    input logic [2:0]    host_sel,
    input logic          host_ready,
    input logic          host_rvalid,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] wr_ptr
);
    logic acc_rd, acc_wdat;
    assign acc_rd   = host_req && host_ready && !host_we;
    assign acc_wdat = host_req && host_ready && host_we && host_sel == 3'd2;

    p_rvalid_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> host_rvalid);

    p_no_stray_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !host_rvalid);

    p_busy_two_cycles_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_ready) |=> !host_ready ##1 host_ready);

    p_wptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wdat |=> wr_ptr == $past(wr_ptr) + PW'(4));

    p_busy_holds_ptrs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |=> $stable(rd_ptr) && $stable(wr_ptr));
endmodule

bind imw_window imw_window_chk #(.PW(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_sel(host_sel), .host_ready(host_ready), .host_rvalid(host_rvalid),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
);

// File: tb/imw_window_test.sv
`timescale 1ns/1ps
module imw_window_test;
    localparam int DEPTH = 16;
    localparam int NREG  = 4;
    localparam logic [31:0] PMOD = 32'(DEPTH * 4);

    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_req = 0, host_we = 0;
    logic [2:0]  host_sel = 0;
    logic [31:0] host_wdata = 0;
    logic        host_ready, host_rvalid;
    logic [31:0] host_rdata;

    int total = 0, bad = 0;
    bit done = 0;

    logic [31:0] mem_m [DEPTH];
    logic [31:0] per_m [NREG];
    logic [31:0] rp_m, wp_m, pws_m, prs_m;

    imw_window #(.MEM_DEPTH(DEPTH), .PER_REGS(NREG)) uut (.*);

    always #4 clk = ~clk;

    function automatic logic [31:0] lane_mask(input logic [1:0] s);
        return (s == 2'd3) ? 32'hFFFF_FFFF : ((32'h1 << (8 * (int'(s) + 1))) - 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                      output logic [31:0] rd);
        while (!host_ready) @(negedge clk);
        host_req = 1; host_we = we; host_sel = sel; host_wdata = wd;
        @(negedge clk);
        host_req = 0;
        rd = host_rdata;
        if (!we) check("R3 rvalid", 32'(host_rvalid), 32'd1);
    endtask

    // model-tracked operations
    task automatic m_write(input logic [2:0] sel, input logic [31:0] d);
        logic [31:0] r;
        op(1, sel, d, r);
        case (sel)
            3'd0: rp_m = d % PMOD;
            3'd1: wp_m = d % PMOD;
            3'd2: begin mem_m[wp_m >> 2] = d; wp_m = (wp_m + 4) % PMOD; end
            3'd4: pws_m = d & 32'h0300_FFFF;
            3'd5: prs_m = d & 32'h0300_FFFF;
            3'd6: begin
                int i = int'(pws_m[15:2]);
                logic [31:0] m = lane_mask(pws_m[25:24]);
                if (i < NREG) per_m[i] = (per_m[i] & ~m) | (d & m);
            end
            default: ;
        endcase
    endtask

    task automatic m_read(input string tag, input logic [2:0] sel);
        logic [31:0] r, e;
        op(0, sel, 0, r);
        case (sel)
            3'd0: e = rp_m;
            3'd1: e = wp_m;
            3'd3: begin e = mem_m[rp_m >> 2]; rp_m = (rp_m + 4) % PMOD; end
            3'd4: e = pws_m;
            3'd5: e = prs_m;
            3'd7: begin
                int i = int'(prs_m[15:2]);
                e = (i < NREG) ? (per_m[i] & lane_mask(prs_m[25:24])) : 32'h0;
            end
            default: e = 0;
        endcase
        check(tag, r, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rp_m = 0; wp_m = 0; pws_m = 0; prs_m = 0;
        for (int i = 0; i < NREG; i++) per_m[i] = 0;

        // R1 reset behaviour
        repeat (3) @(negedge clk);
        check("R1 ready in reset", 32'(host_ready), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 busy after release", 32'(host_ready), 0);
        @(negedge clk);
        check("R1 ready after prefetch", 32'(host_ready), 1);
        m_read("R1 rptr reset", 3'd0);
        m_read("R1 wptr reset", 3'd1);

        // R2 fill memory, R5 wrap of write pointer
        m_write(3'd1, 0);
        for (int i = 0; i < DEPTH; i++) m_write(3'd2, 32'hA500_0000 + 32'(i * 3));
        m_read("R5 wptr wrapped", 3'd1);

        // R4 busy window after pointer load
        begin
            logic [31:0] r;
            op(1, 3'd0, 0, r); rp_m = 0;
            check("R4 busy 1", 32'(host_ready), 0);
            @(negedge clk);
            check("R4 busy 2", 32'(host_ready), 0);
            @(negedge clk);
            check("R4 ready again", 32'(host_ready), 1);
        end

        // R3 sequential reads with R5 wrap
        for (int i = 0; i < DEPTH + 2; i++) m_read("R3 seq read", 3'd3);
        m_read("R5 rptr after wrap", 3'd0);
        m_write(3'd0, 32'hFFFF_FFFC);
        m_read("R5 rptr truncated", 3'd0);
        m_read("R5 read last word", 3'd3);
        m_read("R5 read wraps to 0", 3'd3);

        // R6 write into the prefetched word
        m_write(3'd0, 8);
        m_write(3'd1, 8);
        m_write(3'd2, 32'hC0FF_EE01);
        m_read("R6 snoop read", 3'd3);

        // R9 requests while busy are ignored
        begin
            logic [31:0] r;
            op(1, 3'd0, 32'h10, r); rp_m = 32'h10;
            host_req = 1; host_we = 1; host_sel = 3'd2; host_wdata = 32'hDEAD_BEEF;
            @(negedge clk);
            host_we = 0; host_sel = 3'd1;
            @(negedge clk);
            host_req = 0;
            check("R9 no rvalid when busy", 32'(host_rvalid), 0);
            m_read("R9 wptr unchanged", 3'd1);
            m_read("R9 memory unchanged", 3'd3);
        end

        // R7 / R8 / R10 peripheral path
        m_write(3'd4, 32'h0300_0004);
        m_write(3'd6, 32'h1122_3344);
        m_write(3'd4, 32'h0000_0004);
        m_write(3'd6, 32'hAABB_CCDD);
        m_write(3'd5, 32'h0300_0004);
        m_read("R7 byte lane write", 3'd7);
        m_write(3'd5, 32'h0100_0004);
        m_read("R8 two-byte read", 3'd7);
        m_write(3'd4, 32'h0300_0020);
        m_write(3'd6, 32'h5555_5555);
        m_write(3'd5, 32'h0300_0020);
        m_read("R8 unmapped read zero", 3'd7);
        m_write(3'd5, 32'h0300_0000);
        m_read("R8 unmapped write ignored", 3'd7);
        m_read("R10 write setup readback", 3'd4);
        m_read("R10 read setup readback", 3'd5);
        m_read("R10 write-data reads zero", 3'd2);
        m_read("R10 periph write-data reads zero", 3'd6);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int k = int'($urandom % 10);
            logic [31:0] d = $urandom;
            case (k)
                0: m_write(3'd0, d);
                1: m_write(3'd1, d);
                2, 3: m_write(3'd2, d);
                4, 5: m_read("R3 random read", 3'd3);
                6: m_write(3'(4 + ($urandom % 2)), d & 32'h0300_001F);
                7: m_write(3'd6, d);
                8: m_read("R8 random periph read", 3'd7);
                default: m_read("R5 random ptr read", 3'($urandom % 2));
            endcase
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule